// File: doc/BRIEF.md
# Memory Protect and Privilege Mode Unit

This unit sits between a processor and its memory port. It holds a boundary register, in steps of 256 words, that splits the 15-bit address space into a guarded low region and a free high region. It also keeps a one-bit privilege state, monitor or user. In monitor mode every access and every instruction class goes through. In user mode the unit traps on three things: a privileged instruction class, a boundary-register load, or a memory reference below the boundary. When it traps it suppresses the offending memory request, captures the faulting address and a fault kind, and drops back to monitor mode.

Accepted requests are forwarded with wait states. While protection is enabled every cycle costs one extra clock, and a user-mode write costs a second extra clock. While a forwarded request waits for its grant, a watchdog counts clocks. If no grant arrives in time the watchdog abandons the request and raises a one-cycle non-existent-memory interrupt, so the processor does not hang.

Top module: `mprot_unit`

## Requirements
- R1: After reset the unit is in monitor mode with the trap flag, trap pulse, memory request, busy and interrupt outputs low. The boundary is 0, so no address is guarded.
- R2: With prot_en high and in user mode, an accepted request whose address bits [14:8] are below the boundary never raises mem_req or busy. It sets trap_flag with trap_kind 2, captures the request address in trap_addr and forces monitor mode.
- R3: In monitor mode, requests to any address are forwarded and no instruction class traps. A mode_set pulse enters user mode on the next cycle.
- R4: In user mode, an instruction with class code 1 (I/O), 2 (halt), 3 (chained execute) or 4 (protect-register access) traps with trap_kind 1, captures instr_pc and forces monitor mode. Codes 0 and 5 to 7 never trap.
- R5: A boundary load in monitor mode replaces the boundary with bnd_val. In user mode the load is ignored and traps with trap_kind 3, capturing instr_pc.
- R6: Counting from the clock edge that accepts a request, mem_req rises one cycle later when prot_en is low, two cycles later when prot_en is high, and three cycles later for a user-mode write with prot_en high. busy is high from acceptance until completion.
- R7: trap_flag stays high until trap_clr is pulsed. A new trap in the same cycle as trap_clr wins. trap_pulse is high for exactly one cycle per trap.
- R8: If no grant arrives, mem_req stays high for WD_LIMIT cycles, then drops, and nxm_irq pulses for one cycle.
- R9: mem_addr and mem_wr carry the accepted request. mem_req and busy fall in the cycle after mem_gnt is sampled high, with no interrupt.
- R10: Requests presented while busy is high are ignored: the forwarded address does not change, no trap is raised and no second access follows.
- R11: When several trap causes occur in one cycle, the instruction trap takes precedence over the address trap, which takes precedence over the register-load trap. Any trap overrides a simultaneous mode_set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_en | input | 1 | Protection enabled: address checks and wait states |
| mode_set | input | 1 | Pulse: enter user mode |
| trap_clr | input | 1 | Pulse: clear the trap flag |
| instr_vld | input | 1 | Instruction class below is valid this cycle |
| instr_cls | input | 3 | Instruction class code |
| instr_pc | input | 15 | Address of the current instruction |
| bnd_ld | input | 1 | Boundary register load strobe |
| bnd_val | input | 7 | New boundary, in 256-word pages |
| req_vld | input | 1 | Memory request valid |
| req_addr | input | 15 | Memory request address |
| req_wr | input | 1 | Memory request is a write |
| mem_gnt | input | 1 | Memory grant for the forwarded request |
| user_mode | output | 1 | High in user mode |
| trap_flag | output | 1 | Sticky trap indication |
| trap_pulse | output | 1 | One-cycle trap event |
| trap_kind | output | 2 | 1 instruction, 2 address, 3 register load |
| trap_addr | output | 15 | Captured fault address |
| mem_req | output | 1 | Forwarded memory request |
| mem_addr | output | 15 | Forwarded address |
| mem_wr | output | 1 | Forwarded write flag |
| busy | output | 1 | Wait-state indication to the processor |
| nxm_irq | output | 1 | One-cycle non-existent-memory interrupt |

## Verification
Addresses are drawn both uniformly and from the pages just below, at and just above the current boundary. This separates an off-by-one in the page comparison from a correct one. Requests are mixed across both modes, both directions and both prot_en settings, so each of the three wait-state counts is seen and a penalty applied in the wrong case shows up as a latency error. Grants arrive after random delays, including on the last allowed cycle, and some never arrive, which tests that the watchdog expires on time. Directed cycles combine several trap causes, and a trap with a clear or a mode_set, to expose the precedence rules.

// File: rtl/mprot_pkg.sv
`timescale 1ns/1ps
package mprot_pkg;
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_INSTR = 2'd1,
    FLT_ADDR  = 2'd2,
    FLT_REG   = 2'd3
  } flt_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PEN   = 2'd1,
    SQ_ISSUE = 2'd2
  } sq_e;

  // class codes 1..4 are reserved to monitor mode
  function automatic logic is_priv(input logic [2:0] cls);
    return (cls >= 3'd1) && (cls <= 3'd4);
  endfunction
endpackage

// File: rtl/mprot_bound.sv
`timescale 1ns/1ps
module mprot_bound #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 8,
  localparam int BND_W = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_ok_i,
  input  logic [BND_W-1:0]  ld_val_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic              below_o
);
  logic [BND_W-1:0] bnd_q;

  always_ff @(posedge clk) begin
    if (rst)          bnd_q <= '0;
    else if (ld_ok_i) bnd_q <= ld_val_i;
  end

  assign below_o = chk_addr_i[ADDR_W-1:PAGE_W] < bnd_q;

  // R5
  bnd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_ok_i |=> $stable(bnd_q));
endmodule

// File: rtl/mprot_priv.sv
`timescale 1ns/1ps
module mprot_priv
  import mprot_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_vld_i,
  input  logic [2:0]        instr_cls_i,
  input  logic [ADDR_W-1:0] instr_pc_i,
  input  logic              addr_bad_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              bnd_ld_i,
  input  logic              mode_set_i,
  input  logic              trap_clr_i,
  output logic              user_o,
  output logic              trap_o,
  output logic              pulse_o,
  output logic [1:0]        kind_o,
  output logic [ADDR_W-1:0] taddr_o
);
  logic              user_q, trap_q, pulse_q;
  flt_e              kind_q, kind_n;
  logic [ADDR_W-1:0] taddr_q, taddr_n;
  logic              instr_bad, reg_bad, any_bad;

  always_comb begin
    instr_bad = user_q && instr_vld_i && is_priv(instr_cls_i);
    reg_bad   = user_q && bnd_ld_i;
    any_bad   = instr_bad || addr_bad_i || reg_bad;
    if (instr_bad) begin
      kind_n  = FLT_INSTR;
      taddr_n = instr_pc_i;
    end else if (addr_bad_i) begin
      kind_n  = FLT_ADDR;
      taddr_n = req_addr_i;
    end else begin
      kind_n  = FLT_REG;
      taddr_n = instr_pc_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      user_q  <= 1'b0;
      trap_q  <= 1'b0;
      pulse_q <= 1'b0;
      kind_q  <= FLT_NONE;
      taddr_q <= '0;
    end else begin
      pulse_q <= any_bad;
      if (any_bad) begin
        trap_q  <= 1'b1;
        kind_q  <= kind_n;
        taddr_q <= taddr_n;
        user_q  <= 1'b0;
      end else begin
        if (trap_clr_i) trap_q <= 1'b0;
        if (mode_set_i) user_q <= 1'b1;
      end
    end
  end

  assign user_o  = user_q;
  assign trap_o  = trap_q;
  assign pulse_o = pulse_q;
  assign kind_o  = kind_q;
  assign taddr_o = taddr_q;

  // R3
  mon_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!user_q && !addr_bad_i) |=> !pulse_q);
  // R7
  trap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_q && !trap_clr_i) |=> trap_q);
  // R2
  trap_mon_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> (!user_q && trap_q));
  // R11
  trap_beats_set_chk: assert property (@(posedge clk) disable iff (rst)
    (any_bad && mode_set_i) |=> !user_q);
endmodule

// File: rtl/mprot_seq.sv
`timescale 1ns/1ps
module mprot_seq
  import mprot_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int WD_LIMIT = 16,
  localparam int WD_W    = (WD_LIMIT > 1) ? $clog2(WD_LIMIT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_vld_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_wr_i,
  input  logic              viol_i,
  input  logic [1:0]        pen_i,
  input  logic              mem_gnt_i,
  output logic              acc_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_wr_o,
  output logic              busy_o,
  output logic              nxm_o
);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(WD_LIMIT - 1);

  sq_e               st_q;
  logic [1:0]        pen_q;
  logic [WD_W-1:0]   wd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q, nxm_q;

  assign acc_o = req_vld_i && (st_q == SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SQ_IDLE;
      pen_q  <= '0;
      wd_q   <= '0;
      addr_q <= '0;
      wr_q   <= 1'b0;
      nxm_q  <= 1'b0;
    end else begin
      nxm_q <= 1'b0;
      unique case (st_q)
        SQ_IDLE: begin
          if (acc_o && !viol_i) begin
            addr_q <= req_addr_i;
            wr_q   <= req_wr_i;
            wd_q   <= '0;
            if (pen_i == 2'd0) begin
              st_q <= SQ_ISSUE;
            end else begin
              st_q  <= SQ_PEN;
              pen_q <= pen_i;
            end
          end
        end
        SQ_PEN: begin
          if (pen_q == 2'd1) st_q <= SQ_ISSUE;
          pen_q <= pen_q - 2'd1;
        end
        SQ_ISSUE: begin
          if (mem_gnt_i) begin
            st_q <= SQ_IDLE;
          end else if (wd_q == WD_LAST) begin
            st_q  <= SQ_IDLE;
            nxm_q <= 1'b1;
          end else begin
            wd_q <= wd_q + 1'b1;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (st_q == SQ_ISSUE);
  assign busy_o     = (st_q != SQ_IDLE);
  assign mem_addr_o = addr_q;
  assign mem_wr_o   = wr_q;
  assign nxm_o      = nxm_q;

  // R8
  wd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_gnt_i && wd_q != WD_LAST) |=> mem_req_o);
  // R8
  nxm_src_chk: assert property (@(posedge clk) disable iff (rst)
    nxm_q |-> $past(mem_req_o && !mem_gnt_i));
  // R9
  gnt_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_gnt_i) |=> (!mem_req_o && !nxm_q));
  // R10
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> ($stable(mem_addr_o) && $stable(mem_wr_o)));
  // R6
  pen_len_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_PEN && pen_q == 2'd1) |=> mem_req_o);
endmodule

// File: rtl/mprot_unit.sv
`timescale 1ns/1ps
module mprot_unit #(
  parameter int ADDR_W   = 15,
  parameter int PAGE_W   = 8,
  parameter int WD_LIMIT = 16,
  localparam int BND_W   = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prot_en,
  input  logic              mode_set,
  input  logic              trap_clr,
  input  logic              instr_vld,
  input  logic [2:0]        instr_cls,
  input  logic [ADDR_W-1:0] instr_pc,
  input  logic              bnd_ld,
  input  logic [BND_W-1:0]  bnd_val,
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wr,
  input  logic              mem_gnt,
  output logic              user_mode,
  output logic              trap_flag,
  output logic              trap_pulse,
  output logic [1:0]        trap_kind,
  output logic [ADDR_W-1:0] trap_addr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr,
  output logic              busy,
  output logic              nxm_irq
);
  logic       below, viol, acc, ld_ok;
  logic [1:0] pen;

  assign ld_ok = bnd_ld && !user_mode;
  assign viol  = prot_en && user_mode && below;
  assign pen   = !prot_en ? 2'd0 : ((user_mode && req_wr) ? 2'd2 : 2'd1);

  mprot_bound #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_bound (
    .clk        (clk),
    .rst        (rst),
    .ld_ok_i    (ld_ok),
    .ld_val_i   (bnd_val),
    .chk_addr_i (req_addr),
    .below_o    (below)
  );

  mprot_priv #(.ADDR_W(ADDR_W)) u_priv (
    .clk         (clk),
    .rst         (rst),
    .instr_vld_i (instr_vld),
    .instr_cls_i (instr_cls),
    .instr_pc_i  (instr_pc),
    .addr_bad_i  (acc && viol),
    .req_addr_i  (req_addr),
    .bnd_ld_i    (bnd_ld),
    .mode_set_i  (mode_set),
    .trap_clr_i  (trap_clr),
    .user_o      (user_mode),
    .trap_o      (trap_flag),
    .pulse_o     (trap_pulse),
    .kind_o      (trap_kind),
    .taddr_o     (trap_addr)
  );

  mprot_seq #(.ADDR_W(ADDR_W), .WD_LIMIT(WD_LIMIT)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_vld_i  (req_vld),
    .req_addr_i (req_addr),
    .req_wr_i   (req_wr),
    .viol_i     (viol),
    .pen_i      (pen),
    .mem_gnt_i  (mem_gnt),
    .acc_o      (acc),
    .mem_req_o  (mem_req),
    .mem_addr_o (mem_addr),
    .mem_wr_o   (mem_wr),
    .busy_o     (busy),
    .nxm_o      (nxm_irq)
  );

  // R2
  sup_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && viol) |=> (!mem_req && !busy && trap_flag));
endmodule

// File: tb/mprot_unit_tb.sv
`timescale 1ns/1ps
module mprot_unit_tb;
  localparam int WD = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prot_en = 0, mode_set = 0, trap_clr = 0, instr_vld = 0;
  logic [2:0] instr_cls = '0;
  logic [14:0] instr_pc = '0;
  logic bnd_ld = 0;
  logic [6:0] bnd_val = '0;
  logic req_vld = 0, req_wr = 0, mem_gnt = 0;
  logic [14:0] req_addr = '0;
  logic user_mode, trap_flag, trap_pulse, mem_req, mem_wr, busy, nxm_irq;
  logic [1:0] trap_kind;
  logic [14:0] trap_addr, mem_addr;

  int checks = 0, errors = 0;
  logic m_user = 0, m_pen = 0, m_trap = 0;
  logic [6:0] m_bnd = '0;
  logic [1:0] m_kind = '0;
  logic [14:0] m_taddr = '0;

  always #5 clk = ~clk;

  mprot_unit #(.WD_LIMIT(WD)) u_dut (
    .clk(clk), .rst(rst), .prot_en(prot_en), .mode_set(mode_set), .trap_clr(trap_clr),
    .instr_vld(instr_vld), .instr_cls(instr_cls), .instr_pc(instr_pc),
    .bnd_ld(bnd_ld), .bnd_val(bnd_val), .req_vld(req_vld), .req_addr(req_addr),
    .req_wr(req_wr), .mem_gnt(mem_gnt), .user_mode(user_mode), .trap_flag(trap_flag),
    .trap_pulse(trap_pulse), .trap_kind(trap_kind), .trap_addr(trap_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wr(mem_wr), .busy(busy), .nxm_irq(nxm_irq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic bit is_priv_cls(input logic [2:0] c);
    return (c >= 3'd1) && (c <= 3'd4);
  endfunction

  function automatic int exp_pen(input logic wr);
    if (!m_pen) return 0;
    return (m_user && wr) ? 2 : 1;
  endfunction

  task automatic trap_model(input logic [1:0] k, input logic [14:0] a);
    m_trap = 1; m_kind = k; m_taddr = a; m_user = 0;
  endtask

  task automatic check_state(input string rq);
    chk(user_mode == m_user, rq, "user_mode", user_mode, m_user);
    chk(trap_flag == m_trap, rq, "trap_flag", trap_flag, m_trap);
    if (m_trap) begin
      chk(trap_kind == m_kind, rq, "trap_kind", trap_kind, m_kind);
      chk(trap_addr == m_taddr, rq, "trap_addr", trap_addr, m_taddr);
    end
  endtask

  task automatic do_mode();
    mode_set = 1; tick(); mode_set = 0;
    m_user = 1;
    check_state("R3");
  endtask

  task automatic do_clr();
    trap_clr = 1; tick(); trap_clr = 0;
    m_trap = 0;
    chk(trap_flag == 1'b0, "R7", "trap_flag after clear", trap_flag, 0);
  endtask

  task automatic do_instr(input logic [2:0] cls, input logic [14:0] pc);
    bit hit;
    instr_vld = 1; instr_cls = cls; instr_pc = pc;
    tick();
    instr_vld = 0;
    hit = m_user && is_priv_cls(cls);
    if (hit) trap_model(2'd1, pc);
    chk(trap_pulse == hit, "R4", "trap_pulse on instr", trap_pulse, hit);
    check_state("R4");
  endtask

  task automatic do_bnd(input logic [6:0] v, input logic [14:0] pc);
    bnd_ld = 1; bnd_val = v; instr_pc = pc;
    tick();
    bnd_ld = 0;
    if (m_user) trap_model(2'd3, pc);
    else m_bnd = v;
    check_state("R5");
  endtask

  task automatic do_req(input logic [14:0] a, input logic wr, input int gd,
                        input bit tmo, input bit poke);
    bit viol;
    int pen, n;
    viol = m_pen && m_user && (a[14:8] < m_bnd);
    pen = exp_pen(wr);
    req_vld = 1; req_addr = a; req_wr = wr;
    tick();
    req_vld = 0;
    if (viol) begin
      trap_model(2'd2, a);
      check_state("R2");
      chk(mem_req == 0 && busy == 0, "R2", "suppressed req/busy", {mem_req, busy}, 0);
      tick();
      chk(mem_req == 0, "R2", "no late mem_req", mem_req, 0);
      return;
    end
    chk(busy == 1'b1, "R6", "busy after accept", busy, 1);
    n = 0;
    while (!mem_req && n < 8) begin
      tick();
      n++;
    end
    chk(n == pen, "R6", "wait states", n, pen);
    chk(mem_addr == a && mem_wr == wr, "R9", "forwarded addr/wr", {mem_wr, mem_addr}, {wr, a});
    if (poke) begin
      req_vld = 1; req_addr = a ^ 15'h5a5a; req_wr = !wr;
      tick();
      req_vld = 0;
      chk(mem_addr == a, "R10", "addr while busy", mem_addr, a);
      chk(trap_pulse == 0, "R10", "no trap while busy", trap_pulse, 0);
    end
    if (tmo) begin
      for (int i = (poke ? 2 : 1); i < WD; i++) tick();
      chk(mem_req == 1'b1, "R8", "req held to limit", mem_req, 1);
      tick();
      chk(mem_req == 0 && nxm_irq == 1, "R8", "timeout req/irq", {mem_req, nxm_irq}, 1);
      tick();
      chk(nxm_irq == 0, "R8", "irq one cycle", nxm_irq, 0);
    end else begin
      for (int i = 0; i < gd; i++) tick();
      mem_gnt = 1; tick(); mem_gnt = 0;
      chk(mem_req == 0 && busy == 0 && nxm_irq == 0, "R9", "after grant",
          {mem_req, busy, nxm_irq}, 0);
      if (poke) begin
        tick();
        chk(mem_req == 0 && busy == 0, "R10", "no second access", {mem_req, busy}, 0);
      end
    end
    check_state("R9");
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    tick();
    // R1 reset state
    chk(user_mode == 0 && trap_flag == 0 && trap_pulse == 0, "R1", "mode/trap",
        {user_mode, trap_flag, trap_pulse}, 0);
    chk(mem_req == 0 && busy == 0 && nxm_irq == 0, "R1", "req/busy/irq",
        {mem_req, busy, nxm_irq}, 0);
    prot_en = 1; m_pen = 1;
    do_mode();
    do_req(15'h0000, 1, 0, 0, 0);     // R1: boundary 0 guards nothing
    do_bnd(7'h10, 15'h0123);          // R5: user load traps, ignored
    do_clr();
    do_mode();
    do_req(15'h0005, 0, 1, 0, 0);     // R5: boundary still 0
    do_instr(3'd1, 15'h0200);         // R4
    do_clr();
    do_bnd(7'h10, 15'h0124);          // R5: monitor load
    do_req(15'h0FFF, 1, 2, 0, 0);     // R3: monitor reaches guarded page
    do_instr(3'd2, 15'h0300);         // R3: monitor class 2 no trap
    do_mode();
    do_req(15'h0FFF, 1, 0, 0, 0);     // R2: page just below boundary
    do_clr();
    do_mode();
    do_req(15'h1000, 1, 3, 0, 0);     // R2/R6: boundary page, user write
    do_req(15'h1000, 0, 0, 0, 0);     // R6: user read
    prot_en = 0; m_pen = 0;
    do_req(15'h0000, 1, 0, 0, 0);     // R6: no protection, no penalty
    prot_en = 1; m_pen = 1;
    for (int c = 0; c < 8; c++) begin // R4 every class code
      if (!m_user) do_mode();
      do_instr(3'(c), 15'(16'h0400 + c));
    end
    do_req(15'h2000, 0, WD - 1, 0, 0); // R9: grant on last cycle
    do_req(15'h3000, 1, 0, 1, 0);      // R8: timeout
    do_req(15'h3100, 0, 2, 0, 1);      // R10: busy ignores requests
    // R11: instr beats addr beats reg; trap beats mode_set and clear
    if (!m_user) do_mode();
    instr_vld = 1; instr_cls = 3'd2; instr_pc = 15'h0777;
    req_vld = 1; req_addr = 15'h0100; req_wr = 0;
    bnd_ld = 1; bnd_val = 7'h00; mode_set = 1; trap_clr = 1;
    tick();
    instr_vld = 0; req_vld = 0; bnd_ld = 0; mode_set = 0; trap_clr = 0;
    trap_model(2'd1, 15'h0777);
    check_state("R11");
    chk(mem_req == 0 && busy == 0, "R11", "req suppressed", {mem_req, busy}, 0);
    do_mode();
    req_vld = 1; req_addr = 15'h0200; req_wr = 1; bnd_ld = 1; bnd_val = 7'h00;
    instr_pc = 15'h0555;
    tick();
    req_vld = 0; bnd_ld = 0;
    trap_model(2'd2, 15'h0200);
    check_state("R11");
    do_req(15'h0FFF, 0, 0, 0, 0);     // R11: boundary kept (monitor, 0x10)
    do_mode();
    do_req(15'h0F00, 0, 0, 0, 0);     // R11: still guarded, so load was dropped
    // random mix
    for (int it = 0; it < 400; it++) begin
      int r;
      logic [14:0] a;
      r = int'($urandom % 12);
      case (r)
        0: do_mode();
        1: do_clr();
        2: do_bnd(7'($urandom), 15'($urandom));
        3: do_instr(3'($urandom), 15'($urandom));
        4: begin
          m_pen = 1'($urandom);
          prot_en = m_pen;
        end
        default: begin
          if ($urandom % 2 == 0) a = 15'($urandom);
          else a = {7'(m_bnd + 7'($urandom % 3) - 7'd1), 8'($urandom)};
          do_req(a, 1'($urandom), int'($urandom % (WD - 2)),
                 ($urandom % 10) == 0, ($urandom % 6) == 0);
        end
      endcase
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule